// File: doc/BRIEF.md
# Hitless Reference Selector with Prescaler

This block takes two timing references, a primary and a secondary, that run at the same nominal rate. It samples both with a fast local system clock and turns each falling edge into an event. It then divides each event stream down to a common 8 kHz frame rate and hands one stream onward, as a single-cycle pulse, to a downstream phase-locked loop. The input rate is one of four, picked by a two-bit code that the block takes in while reset is held.

Changing from one reference to the other normally shifts the phase of the frame pulse, because the two sources are not aligned. When correction is enabled, the block holds the changeover until the next frame event of the incoming reference arrives. It measures how early or late that event is against the frame the outgoing reference would have produced. It adds that difference, modulo the frame period, to every later event, so the pulse train toward the loop keeps its spacing. When correction is disabled, the selection takes effect at once and events pass with no added delay.

Top module: `hitless_refsel`

## Requirements
- R1: While reset is held and right after it, `evt_o` is 0, `offset_o` is 0 and `active_sec_o` is 0, so the primary reference is in use.
- R2: Only falling edges of a reference count as events. Moving the rising edge of an input without moving its falling edge leaves the output pulse spacing unchanged.
- R3: The rate code selects the prescale ratio: 2'b00 gives `DIV_C00` (2430 by default, 19.44 MHz), 2'b01 gives `DIV_C01` (1, 8 kHz), 2'b10 gives `DIV_C10` (193, 1.544 MHz) and 2'b11 gives `DIV_C11` (256, 2.048 MHz). One output pulse is made per that many falling edges of the active input.
- R4: The rate code is captured only while reset is asserted. A later change of `fsel_i` without a reset has no effect on the pulse spacing.
- R5: `use_sec_i` = 1 asks for the secondary reference and 0 asks for the primary. `active_sec_o` shows which reference is in use (1 = secondary).
- R6: With `corr_en_i` = 1, a change of reference takes effect on the first frame event of the incoming reference after the request. Across the change, the spacing of `evt_o` pulses stays equal to `PERIOD` system clock cycles.
- R7: At each corrected changeover the applied offset becomes (previous offset + expected outgoing event time − incoming event time) modulo `PERIOD`. The offset stays below `PERIOD` and is constant between changeovers. Switching away and back to the same reference restores the earlier offset.
- R8: With `corr_en_i` = 0, the offset is 0, a change of reference takes effect in the next cycle, and the first pulse after the change follows the incoming reference's own timing.
- R9: Every `evt_o` pulse lasts exactly one system clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that samples both references |
| rst_ni | input | 1 | Asynchronous active-low reset; the rate code is captured while low |
| ref_pri_i | input | 1 | Primary timing reference, asynchronous |
| ref_sec_i | input | 1 | Secondary timing reference, asynchronous |
| fsel_i | input | 2 | Input rate code (see R3) |
| use_sec_i | input | 1 | Reference request: 1 secondary, 0 primary |
| corr_en_i | input | 1 | Enables phase-step correction at changeover |
| evt_o | output | 1 | One-cycle pulse per (corrected) 8 kHz frame event |
| offset_o | output | $clog2(PERIOD) | Offset currently applied, in system clock cycles |
| active_sec_o | output | 1 | Reference in use: 1 secondary, 0 primary |

## Verification
The bench drives two references with a fixed phase gap and switches between them directly after a frame pulse. A corrector that swapped at once, or used the wrong sign of the measured gap, would show a short pulse interval or a wrong offset in place of an unbroken spacing. Switching back must return the offset to zero; a design that forgot the modulo wrap would hold a value equal to the period. Moving only the rising edge of an input catches a detector that also reacts to rising edges. Changing the rate code without a reset catches a prescaler that reads the live code instead of the captured one.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

   typedef enum logic [1:0] {
      FS_19M44  = 2'b00,
      FS_8K     = 2'b01,
      FS_1M544  = 2'b10,
      FS_2M048  = 2'b11
   } fsel_e;

   function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                           input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/refsel_edge.sv
module refsel_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic din_i,
   output logic fall_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("refsel_edge: SYNC_STAGES must be at least 2");
   end

   // sh_q[0] is the newest sample; sh_q[SYNC_STAGES-1] is the settled value
   logic [SYNC_STAGES:0] sh_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[SYNC_STAGES-1:0], din_i};
   end

   assign fall_o = sh_q[SYNC_STAGES] & ~sh_q[SYNC_STAGES-1];

   // R2: a falling edge gives exactly one event cycle
   p_fall_isolated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_o |=> !fall_o);

endmodule

// File: rtl/refsel_prescale.sv
module refsel_prescale #(
   parameter int DIVW = 12
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            fall_i,
   input  logic [DIVW-1:0] ratio_i,
   output logic            strobe_o
);

   if (DIVW < 1) begin : g_bad_divw
      $error("refsel_prescale: DIVW must be positive");
   end

   logic [DIVW-1:0] cnt_q;
   logic [DIVW:0]   nxt;
   logic            wrap;
   logic            strobe_q;

   assign nxt  = {1'b0, cnt_q} + (DIVW+1)'(1);
   assign wrap = nxt >= {1'b0, ratio_i};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q    <= '0;
         strobe_q <= 1'b0;
      end else begin
         strobe_q <= fall_i & wrap;
         if (fall_i) cnt_q <= wrap ? '0 : nxt[DIVW-1:0];
      end
   end

   assign strobe_o = strobe_q;

   // R3: a frame event only follows a counted falling edge
   p_strobe_from_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      strobe_o |-> $past(fall_i));

   // R3: the edge count never reaches the ratio
   p_cnt_below_ratio_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q < ratio_i);

endmodule

// File: rtl/refsel_delay.sv
module refsel_delay #(
   parameter int OFFW = 8
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            load_i,
   input  logic [OFFW-1:0] len_i,
   output logic            pulse_o
);

   logic [OFFW-1:0] dly_q;
   logic            busy_q;
   logic            pulse_q;
   logic            fire_now;
   logic            zero_len;

   assign fire_now = busy_q && (dly_q == OFFW'(1));
   assign zero_len = load_i && (len_i == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         dly_q   <= '0;
         busy_q  <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= zero_len | fire_now;
         if (load_i && (len_i != '0)) begin
            // a pending event with the same target is simply overwritten
            dly_q  <= len_i;
            busy_q <= 1'b1;
         end else if (busy_q) begin
            dly_q  <= dly_q - OFFW'(1);
            busy_q <= !fire_now;
         end
      end
   end

   assign pulse_o = pulse_q;

   // R9: an event with no offset leaves on the next cycle
   p_zero_len_next_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      zero_len |=> pulse_o);

endmodule

// File: rtl/hitless_refsel.sv
module hitless_refsel
   import refsel_pkg::*;
#(
   parameter int PERIOD       = 9720,
   parameter int SYNC_STAGES  = 2,
   parameter int DIV_C00      = 2430,
   parameter int DIV_C01      = 1,
   parameter int DIV_C10      = 193,
   parameter int DIV_C11      = 256,
   parameter bit CORR_PRESENT = 1'b1,
   localparam int OFFW        = $clog2(PERIOD)
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            ref_pri_i,
   input  logic            ref_sec_i,
   input  logic [1:0]      fsel_i,
   input  logic            use_sec_i,
   input  logic            corr_en_i,
   output logic            evt_o,
   output logic [OFFW-1:0] offset_o,
   output logic            active_sec_o
);

   localparam int CNTW   = $clog2(PERIOD + 1);
   localparam int DIVMAX = int'(max_of4(DIV_C00, DIV_C01, DIV_C10, DIV_C11));
   localparam int DIVW   = $clog2(DIVMAX + 1);
   localparam int NREF   = 2;

   if (PERIOD < 2) begin : g_bad_period
      $error("hitless_refsel: PERIOD must be at least 2");
   end
   if (DIV_C00 < 1 || DIV_C01 < 1 || DIV_C10 < 1 || DIV_C11 < 1) begin : g_bad_div
      $error("hitless_refsel: every prescale ratio must be at least 1");
   end

   // ---------------- rate code, captured only while reset is held
   fsel_e           fsel_q;
   logic [DIVW-1:0] ratio;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fsel_q <= fsel_e'(fsel_i);
   end

   always_comb begin
      unique case (fsel_q)
         FS_19M44: ratio = DIVW'(DIV_C00);
         FS_8K:    ratio = DIVW'(DIV_C01);
         FS_1M544: ratio = DIVW'(DIV_C10);
         default:  ratio = DIVW'(DIV_C11);
      endcase
   end

   // ---------------- per-reference edge detection and prescaling
   logic [NREF-1:0] ref_in;
   logic [NREF-1:0] fall;
   logic [NREF-1:0] strobe;

   assign ref_in = {ref_sec_i, ref_pri_i};

   for (genvar g = 0; g < NREF; g++) begin : g_ref
      refsel_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .din_i  (ref_in[g]),
         .fall_o (fall[g])
      );
      refsel_prescale #(.DIVW(DIVW)) u_pre (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .fall_i   (fall[g]),
         .ratio_i  (ratio),
         .strobe_o (strobe[g])
      );
   end

   // ---------------- selection and phase-step measurement
   logic            act_q;
   logic [OFFW-1:0] off_q;
   logic [CNTW-1:0] age_q;

   logic            corr_on;
   logic            want_swap;
   logic            strobe_old;
   logic            strobe_new;
   logic            swap;
   logic            ev_sel;
   logic [CNTW-1:0] gap;
   logic [CNTW:0]   sum;
   logic [OFFW-1:0] off_wrap;
   logic [OFFW-1:0] off_d;
   logic [CNTW-1:0] age_d;

   assign corr_on    = CORR_PRESENT && corr_en_i;
   assign want_swap  = use_sec_i != act_q;
   assign strobe_old = strobe[act_q];
   assign strobe_new = strobe[~act_q];
   assign swap       = corr_on ? (want_swap && strobe_new) : want_swap;
   assign ev_sel     = (corr_on && swap) ? 1'b1 : strobe_old;

   // age_q is the distance since the last active event, clipped to PERIOD
   assign gap      = CNTW'(PERIOD) - age_q;
   assign sum      = (CNTW+1)'(off_q) + (CNTW+1)'(gap);
   assign off_wrap = (sum >= (CNTW+1)'(PERIOD)) ? OFFW'(sum - (CNTW+1)'(PERIOD))
                                                : OFFW'(sum);

   always_comb begin
      if (!corr_on)  off_d = '0;
      else if (swap) off_d = off_wrap;
      else           off_d = off_q;
      if (ev_sel)                        age_d = CNTW'(1);
      else if (age_q == CNTW'(PERIOD))   age_d = age_q;
      else                               age_d = age_q + CNTW'(1);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_q <= 1'b0;
         off_q <= '0;
         age_q <= CNTW'(PERIOD);
      end else begin
         act_q <= swap ? ~act_q : act_q;
         off_q <= off_d;
         age_q <= age_d;
      end
   end

   // ---------------- output stage: delay line or plain register
   if (CORR_PRESENT) begin : g_delay
      refsel_delay #(.OFFW(OFFW)) u_dly (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .load_i  (ev_sel),
         .len_i   (off_d),
         .pulse_o (evt_o)
      );
   end else begin : g_plain
      logic evt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) evt_q <= 1'b0;
         else         evt_q <= ev_sel;
      end
      assign evt_o = evt_q;
   end

   assign offset_o     = off_q;
   assign active_sec_o = act_q;

   // R7: the applied offset is always a valid phase within one frame
   p_offset_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      offset_o < OFFW'(PERIOD));

   // R7: with correction on and no changeover the offset does not move
   p_offset_steady_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(corr_en_i) && $stable(active_sec_o) |-> $stable(offset_o));

   // R8: correction off means no offset in the next cycle
   p_off_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !corr_en_i |=> offset_o == '0);

   // R6: a corrected changeover lands only on an incoming-reference event
   p_swap_on_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(corr_en_i) && !$stable(active_sec_o) |-> $past(strobe_new));

endmodule

// File: tb/hitless_refsel_tb.sv
module hitless_refsel_tb;

   localparam int CLK_NS = 10;
   localparam int PER    = 40;
   localparam int OFFW   = $clog2(PER);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            ref_pri = 1'b0;
   logic            ref_sec = 1'b0;
   logic [1:0]      fsel = 2'b01;
   logic            use_sec = 1'b0;
   logic            corr_en = 1'b0;
   logic            evt;
   logic [OFFW-1:0] offset;
   logic            act_sec;

   int n_chk = 0;
   int n_fail = 0;

   // reference waveform settings: period, phase, rising point
   int p_ref = PER;
   int ph_a = 0;
   int ph_b = 13;
   int r_a = 0;
   int r_b = 0;

   int tick = 0;
   int last_t = 0;
   int last_intv = 0;
   int npulse = 0;
   bit have_last = 0;
   bit prev_evt = 0;
   int dbl = 0;

   always #(CLK_NS/2) clk = ~clk;

   hitless_refsel #(
      .PERIOD(PER), .SYNC_STAGES(2),
      .DIV_C00(2), .DIV_C01(1), .DIV_C10(4), .DIV_C11(5),
      .CORR_PRESENT(1'b1)
   ) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .ref_pri_i(ref_pri), .ref_sec_i(ref_sec),
      .fsel_i(fsel), .use_sec_i(use_sec), .corr_en_i(corr_en),
      .evt_o(evt), .offset_o(offset), .active_sec_o(act_sec)
   );

   // reference generation and output monitor, away from the active edge
   always @(negedge clk) begin
      int ma;
      int mb;
      tick = tick + 1;
      ma = (tick + p_ref * 1000 - ph_a) % p_ref;
      mb = (tick + p_ref * 1000 - ph_b) % p_ref;
      ref_pri <= (ma >= r_a) && (ma < p_ref / 2);
      ref_sec <= (mb >= r_b) && (mb < p_ref / 2);
      if (evt) begin
         if (have_last) last_intv = tick - last_t;
         last_t = tick;
         have_last = 1'b1;
         npulse = npulse + 1;
      end
      if (evt && prev_evt) dbl = dbl + 1;
      prev_evt = evt;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk = n_chk + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_pulse(output int intv);
      int s;
      s = npulse;
      while (npulse == s) @(posedge clk);
      intv = last_intv;
   endtask

   task automatic expect_intervals(input int n, input int exp, input string req);
      int v;
      for (int i = 0; i < n; i++) begin
         wait_pulse(v);
         chk(v == exp, req, v, exp);
      end
   endtask

   task automatic do_reset(input logic [1:0] code, input logic corr);
      @(negedge clk);
      fsel    = code;
      corr_en = corr;
      use_sec = 1'b0;
      rst_n   = 1'b0;
      repeat (3) @(negedge clk);
      rst_n   = 1'b1;
      have_last = 1'b0;
   endtask

   // R1: state during and just after reset
   task automatic t_reset();
      int v;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(evt == 1'b0, "R1 evt in reset", evt, 0);
      chk(offset == '0, "R1 offset in reset", offset, 0);
      chk(act_sec == 1'b0, "R1 active in reset", act_sec, 0);
      rst_n = 1'b1;
      have_last = 1'b0;
      @(negedge clk);
      chk(act_sec == 1'b0, "R1 active after reset", act_sec, 0);
      chk(offset == '0, "R1 offset after reset", offset, 0);
      wait_pulse(v);
   endtask

   // R3: each rate code with its own input period
   task automatic t_prescale(input logic [1:0] code, input int in_per);
      int v;
      p_ref = in_per;
      ph_a = 0; ph_b = 0; r_a = 0; r_b = 0;
      do_reset(code, 1'b0);
      wait_pulse(v);
      wait_pulse(v);
      expect_intervals(3, PER, "R3 prescale spacing");
   endtask

   // R4: live code change without reset is ignored
   task automatic t_code_hold();
      int v;
      p_ref = PER; ph_a = 0; ph_b = 13; r_a = 0; r_b = 0;
      do_reset(2'b01, 1'b0);
      wait_pulse(v);
      @(negedge clk);
      fsel = 2'b00;
      wait_pulse(v);
      expect_intervals(3, PER, "R4 code held");
      fsel = 2'b01;
   endtask

   // R2: moving only the rising edge has no effect
   task automatic t_rise_only();
      int v;
      wait_pulse(v);
      @(negedge clk);
      r_a = 7;
      wait_pulse(v);
      expect_intervals(2, PER, "R2 rising edge moved");
      @(negedge clk);
      r_a = 15;
      wait_pulse(v);
      expect_intervals(2, PER, "R2 rising edge moved again");
      r_a = 0;
   endtask

   // R8 and R5: uncorrected switching
   task automatic t_switch_plain();
      int v;
      p_ref = PER; ph_a = 0; ph_b = 13;
      do_reset(2'b01, 1'b0);
      wait_pulse(v);
      wait_pulse(v);
      @(negedge clk);
      use_sec = 1'b1;
      @(negedge clk);
      chk(act_sec == 1'b1, "R5 secondary in use", act_sec, 1);
      chk(offset == '0, "R8 offset zero", offset, 0);
      wait_pulse(v);
      chk(v == 13, "R8 step follows incoming", v, 13);
      expect_intervals(2, PER, "R8 steady on secondary");
      @(negedge clk);
      use_sec = 1'b0;
      @(negedge clk);
      chk(act_sec == 1'b0, "R5 primary in use", act_sec, 0);
      wait_pulse(v);
      chk(v == 27, "R8 step back follows incoming", v, 27);
   endtask

   // R6 and R7: corrected switching
   task automatic t_switch_corr();
      int v;
      p_ref = PER; ph_a = 0; ph_b = 13;
      do_reset(2'b01, 1'b1);
      wait_pulse(v);
      wait_pulse(v);
      @(negedge clk);
      use_sec = 1'b1;
      repeat (2) @(negedge clk);
      chk(act_sec == 1'b0, "R6 change waits for incoming event", act_sec, 0);
      expect_intervals(4, PER, "R6 no phase step");
      chk(act_sec == 1'b1, "R6 secondary in use", act_sec, 1);
      chk(offset == OFFW'(27), "R7 offset after change", offset, 27);
      @(negedge clk);
      use_sec = 1'b0;
      expect_intervals(4, PER, "R6 no phase step back");
      chk(act_sec == 1'b0, "R6 primary in use", act_sec, 0);
      chk(offset == '0, "R7 offset restored", offset, 0);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      t_reset();
      t_prescale(2'b00, 20);
      t_prescale(2'b01, 40);
      t_prescale(2'b10, 10);
      t_prescale(2'b11, 8);
      t_code_hold();
      t_rise_only();
      t_switch_plain();
      t_switch_corr();
      chk(dbl == 0, "R9 single-cycle pulses", dbl, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL R6 watchdog expired actual=%0d expected=%0d", npulse, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule